// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates an effective address by descending a multi-level radix tree held in memory. The caller gives the address to translate, the base of the root table, the root index width and the initial page-size exponent, then pulses a start strobe. The walker issues one 64-bit read at a time over a request/grant and response memory port. Each level's index width comes from the previous directory entry. The running page-size exponent shrinks by that width at every level.

When a leaf entry is reached, the block reports the real address, the final page-size exponent, the leaf entry word and the address the leaf was read from. Two faults end a walk early. A configuration fault covers an index width that is too small or too large, and a tree deeper than the level cap. A no-entry fault covers a read entry whose valid bit is clear. Only one walk runs at a time. A done pulse marks the end of each walk.

Top module: `rtw_walker`

## Requirements
- R1: After reset the walker is idle: `busy_o`, `done_o` and `mem_req_o` are low and `fault_o` is 2'b00.
- R2: Each entry is read at the table base with its low three bits forced to zero, plus 8 times the index. The index is the effective address shifted right by (current exponent − index width) and masked to the index width.
- R3: An entry with bit 63 set and bit 62 clear is a directory. The next table base is its bits [55:8] followed by eight zero bits. The next index width is its bits [4:0]. The exponent is reduced by the current index width after every read.
- R4: An entry with bits 63 and 62 both set is a leaf, and the walk ends with `fault_o` 2'b00. `raddr_o` takes the leaf's bits [55:0] at and above bit position E and the effective address below it, where E is the remaining exponent. `psize_o` is E, and `leaf_o` and `leaf_addr_o` hold the leaf word and its address. All of these are held until the next walk.
- R5: An entry with bit 63 clear ends the walk with `fault_o` 2'b10, and no further read is made.
- R6: An index width below 5, or above the current exponent, ends the walk with `fault_o` 2'b01 before any read at that level.
- R7: At most 8 entries are read per walk. A directory entry returned by the eighth read ends the walk with `fault_o` 2'b01.
- R8: A request holds `mem_req_o` and `mem_addr_o` steady until `mem_gnt_i`. Only one read is outstanding at a time, and the walker waits any number of cycles for `mem_rvalid_i`.
- R9: `done_o` is a single-cycle pulse. `busy_o` is high from the cycle after an accepted start through the done cycle. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (taken when idle) |
| ea_i | input | 64 | Effective address to translate |
| root_base_i | input | 56 | Root table base address |
| root_isz_i | input | 5 | Root index width |
| root_exp_i | input | 6 | Initial page-size exponent |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| fault_o | output | 2 | 00 none, 01 configuration, 10 no entry |
| raddr_o | output | 56 | Translated real address |
| psize_o | output | 6 | Final page-size exponent |
| leaf_o | output | 64 | Leaf entry word |
| leaf_addr_o | output | 56 | Address of the leaf entry |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 56 | Read address |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |

## Verification
The bench checks each walk that ends on one of the limits.
- Exactly eight levels must succeed, while eight directories must fault. A walker with an off-by-one level counter either faults a legal deep tree or reads a ninth entry.
- An index width of 3, or one larger than the remaining exponent, must fault without a read. A walker that checks only the root would issue a read at a garbage address.
- Leaves at 4K and 2M exponents check the mask width. A mask built from the exponent before the final reduction would leak page-number bits into the offset, and the reverse mistake would drop offset bits.
- Grant stalls, long latencies, an unaligned root base and a start pulse in the middle of a walk show whether the request moves before it is granted, the base bits leak into the address, or a second walk takes over the first.

// File: rtl/rtw_pkg.sv
`timescale 1ns/1ps
package rtw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_EVAL  = 3'd3,
    ST_DONE  = 3'd4
  } walk_st_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_CONFIG = 2'd1,
    FLT_NOENT  = 2'd2
  } flt_e;

  localparam int ENT_W     = 64;
  localparam int VALID_BIT = 63;
  localparam int LEAF_BIT  = 62;
  localparam int ISZ_W     = 5;
  localparam int NB_LO     = 8;
  localparam int MIN_ISZ   = 5;
endpackage

// File: rtl/rtw_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assertion, synchronous two-stage release.
module rtw_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/rtw_index.sv
`timescale 1ns/1ps
// Forms the address of the entry selected by one tree level and
// judges whether the level's index width is usable.
module rtw_index #(
  parameter int EA_W    = 64,
  parameter int PA_W    = 56,
  parameter int EXP_W   = 6,
  parameter int ISZ_W   = 5,
  parameter int MIN_ISZ = 5
) (
  input  logic [EA_W-1:0]  ea,
  input  logic [PA_W-1:0]  base,
  input  logic [EXP_W-1:0] sz_exp,
  input  logic [ISZ_W-1:0] isz,
  output logic [PA_W-1:0]  ent_addr,
  output logic             cfg_ok
);
  logic [EXP_W-1:0] shamt;
  logic [EA_W-1:0]  shifted;
  logic [EA_W-1:0]  idx_mask;
  logic [EA_W-1:0]  index;
  logic [PA_W-1:0]  base_al;

  always_comb begin
    shamt    = sz_exp - EXP_W'(isz);
    shifted  = ea >> shamt;
    idx_mask = (EA_W'(1) << isz) - EA_W'(1);
    index    = shifted & idx_mask;
    base_al  = {base[PA_W-1:3], 3'b000};
    ent_addr = base_al + PA_W'(index << 3);
    cfg_ok   = (isz >= ISZ_W'(MIN_ISZ)) && (EXP_W'(isz) <= sz_exp);
  end
endmodule

// File: rtl/rtw_leaf.sv
`timescale 1ns/1ps
// Merges the leaf's page number with the in-page offset of the address.
module rtw_leaf #(
  parameter int PA_W  = 56,
  parameter int EXP_W = 6
) (
  input  logic [PA_W-1:0]  ea_lo,
  input  logic [PA_W-1:0]  page_bits,
  input  logic [EXP_W-1:0] sz_exp,
  output logic [PA_W-1:0]  raddr
);
  logic [PA_W-1:0] off_mask;

  always_comb begin
    // A shift of PA_W or more gives zero, so the mask becomes all ones.
    off_mask = (PA_W'(1) << sz_exp) - PA_W'(1);
    raddr    = (page_bits & ~off_mask) | (ea_lo & off_mask);
  end
endmodule

// File: rtl/rtw_walker.sv
`timescale 1ns/1ps
module rtw_walker #(
  parameter int EA_W    = 64,
  parameter int PA_W    = 56,
  parameter int EXP_W   = 6,
  parameter int MAX_LVL = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [EA_W-1:0]         ea_i,
  input  logic [PA_W-1:0]         root_base_i,
  input  logic [rtw_pkg::ISZ_W-1:0] root_isz_i,
  input  logic [EXP_W-1:0]        root_exp_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [1:0]              fault_o,
  output logic [PA_W-1:0]         raddr_o,
  output logic [EXP_W-1:0]        psize_o,
  output logic [rtw_pkg::ENT_W-1:0] leaf_o,
  output logic [PA_W-1:0]         leaf_addr_o,
  output logic                    mem_req_o,
  output logic [PA_W-1:0]         mem_addr_o,
  input  logic                    mem_gnt_i,
  input  logic                    mem_rvalid_i,
  input  logic [rtw_pkg::ENT_W-1:0] mem_rdata_i
);
  import rtw_pkg::*;

  localparam int LVL_W = (MAX_LVL > 1) ? $clog2(MAX_LVL) : 1;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(MAX_LVL - 1);

  logic rst_n_s;

  rtw_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  // Control state
  walk_st_e         state_q, state_d;
  flt_e             fault_q, fault_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;

  // Walk context
  logic [EA_W-1:0]  ea_q;
  logic [EXP_W-1:0] exp_q;
  logic [ISZ_W-1:0] isz_q;
  logic [PA_W-1:0]  addr_q;
  logic [ENT_W-1:0] pte_q;

  // Results
  logic [PA_W-1:0]  raddr_q;
  logic [EXP_W-1:0] psize_q;
  logic [ENT_W-1:0] leaf_q;
  logic [PA_W-1:0]  leaf_addr_q;

  // Clock enables
  logic ctx_ld, pte_ld, res_ld, flt_ld;

  // Shared index unit inputs
  logic [EA_W-1:0]  sel_ea;
  logic [PA_W-1:0]  sel_base;
  logic [EXP_W-1:0] sel_exp;
  logic [ISZ_W-1:0] sel_isz;
  logic [PA_W-1:0]  idx_addr;
  logic             idx_ok;
  logic [EXP_W-1:0] exp_rem;
  logic [PA_W-1:0]  leaf_ra;

  assign exp_rem = exp_q - EXP_W'(isz_q);

  always_comb begin
    if (state_q == ST_IDLE) begin
      sel_ea   = ea_i;
      sel_base = root_base_i;
      sel_exp  = root_exp_i;
      sel_isz  = root_isz_i;
    end else begin
      sel_ea   = ea_q;
      sel_base = {pte_q[PA_W-1:NB_LO], {NB_LO{1'b0}}};
      sel_exp  = exp_rem;
      sel_isz  = pte_q[ISZ_W-1:0];
    end
  end

  rtw_index #(
    .EA_W    (EA_W),
    .PA_W    (PA_W),
    .EXP_W   (EXP_W),
    .ISZ_W   (ISZ_W),
    .MIN_ISZ (MIN_ISZ)
  ) u_index (
    .ea       (sel_ea),
    .base     (sel_base),
    .sz_exp   (sel_exp),
    .isz      (sel_isz),
    .ent_addr (idx_addr),
    .cfg_ok   (idx_ok)
  );

  rtw_leaf #(
    .PA_W  (PA_W),
    .EXP_W (EXP_W)
  ) u_leaf (
    .ea_lo     (ea_q[PA_W-1:0]),
    .page_bits (pte_q[PA_W-1:0]),
    .sz_exp    (exp_rem),
    .raddr     (leaf_ra)
  );

  // Next-state process
  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    lvl_d   = lvl_q;
    ctx_ld  = 1'b0;
    pte_ld  = 1'b0;
    res_ld  = 1'b0;
    flt_ld  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ctx_ld = 1'b1;
          flt_ld = 1'b1;
          lvl_d  = '0;
          if (idx_ok) begin
            fault_d = FLT_NONE;
            state_d = ST_ISSUE;
          end else begin
            fault_d = FLT_CONFIG;
            state_d = ST_DONE;
          end
        end
      end
      ST_ISSUE: begin
        if (mem_gnt_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rvalid_i) begin
          pte_ld  = 1'b1;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        state_d = ST_DONE;
        if (!pte_q[VALID_BIT]) begin
          flt_ld  = 1'b1;
          fault_d = FLT_NOENT;
        end else if (pte_q[LEAF_BIT]) begin
          res_ld = 1'b1;
        end else if (lvl_q == LAST_LVL || !idx_ok) begin
          flt_ld  = 1'b1;
          fault_d = FLT_CONFIG;
        end else begin
          ctx_ld  = 1'b1;
          lvl_d   = lvl_q + LVL_W'(1);
          state_d = ST_ISSUE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      fault_q <= FLT_NONE;
      lvl_q   <= '0;
    end else begin
      state_q <= state_d;
      if (flt_ld) fault_q <= fault_d;
      if (ctx_ld) lvl_q   <= lvl_d;
    end
  end

  // Datapath registers
  always_ff @(posedge clk) begin
    if (ctx_ld) begin
      ea_q   <= sel_ea;
      exp_q  <= sel_exp;
      isz_q  <= sel_isz;
      addr_q <= idx_addr;
    end
    if (pte_ld) pte_q <= mem_rdata_i;
    if (res_ld) begin
      raddr_q     <= leaf_ra;
      psize_q     <= exp_rem;
      leaf_q      <= pte_q;
      leaf_addr_q <= addr_q;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign fault_o     = fault_q;
  assign raddr_o     = raddr_q;
  assign psize_o     = psize_q;
  assign leaf_o      = leaf_q;
  assign leaf_addr_o = leaf_addr_q;
  assign mem_req_o   = (state_q == ST_ISSUE);
  assign mem_addr_o  = addr_q;
endmodule

// File: rtl/rtw_walker_chk.sv
`timescale 1ns/1ps
module rtw_walker_chk #(
  parameter int PA_W = 56
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [1:0]      fault_o,
  input logic [63:0]     leaf_o,
  input logic [PA_W-1:0] leaf_addr_o,
  input logic            mem_req_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic            mem_gnt_i
);
  // R1: no traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);

  // R2: entry addresses are 8-byte aligned
  a_r2_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000));

  // R8: request held until granted
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R8: single outstanding read
  a_r8_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_gnt_i) |=> !mem_req_o);

  // R9: done is one cycle wide
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: a walk begins only from a start strobe
  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R4: a successful walk ends on a leaf word
  a_r4_leaf_word: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_o == 2'b00) |-> (leaf_o[63] && leaf_o[62] && leaf_addr_o[2:0] == 3'b000));

  // R5: only defined fault codes
  a_r5_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (fault_o != 2'b11));
endmodule

bind rtw_walker rtw_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .leaf_o      (leaf_o),
  .leaf_addr_o (leaf_addr_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_gnt_i   (mem_gnt_i)
);

// File: tb/rtw_walker_test.sv
`timescale 1ns/1ps
module rtw_walker_test;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [63:0] ea_i;
  logic [55:0] root_base_i;
  logic [4:0]  root_isz_i;
  logic [5:0]  root_exp_i;
  logic        busy_o, done_o;
  logic [1:0]  fault_o;
  logic [55:0] raddr_o;
  logic [5:0]  psize_o;
  logic [63:0] leaf_o;
  logic [55:0] leaf_addr_o;
  logic        mem_req_o;
  logic [55:0] mem_addr_o;
  logic        mem_gnt_i, mem_rvalid_i;
  logic [63:0] mem_rdata_i;

  rtw_walker uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ea_i(ea_i),
    .root_base_i(root_base_i), .root_isz_i(root_isz_i), .root_exp_i(root_exp_i),
    .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .raddr_o(raddr_o),
    .psize_o(psize_o), .leaf_o(leaf_o), .leaf_addr_o(leaf_addr_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [63:0] mem [logic [55:0]];
  logic [55:0] want_q [$];
  int          plan [8];

  // Expected outcome of the current walk
  logic [1:0]  e_fault;
  logic [55:0] e_raddr, e_laddr;
  logic [5:0]  e_psize;
  logic [63:0] e_leaf;

  // Responder and monitor state
  bit          act = 0;
  bit          got_done = 0;
  int          stall_cfg = 0, lat_cfg = 1, stall_cnt = 0, lat_cnt = 0;
  logic [55:0] pend;
  logic [1:0]  s_fault;
  logic [55:0] s_raddr, s_laddr;
  logic [5:0]  s_psize;
  logic [63:0] s_leaf;

  task automatic chk(input bit ok, input string what, input logic [63:0] got, input logic [63:0] want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, want);
    end
  endtask

  function automatic logic [63:0] rd(input logic [55:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  function automatic logic [55:0] ent(input logic [63:0] ea, input logic [55:0] b, input int sz, input int w);
    logic [63:0] idx;
    idx = (ea >> (sz - w)) & ((64'd1 << w) - 64'd1);
    return {b[55:3], 3'b000} + 56'(idx * 8);
  endfunction

  // Behavioural reference: follows the tree in memory
  task automatic model_walk(input logic [63:0] ea, input logic [55:0] b0, input int w0, input int sz0);
    int sz = sz0, w = w0;
    logic [55:0] b = b0, a;
    logic [63:0] d, m;
    want_q.delete();
    e_fault = 2'b00;
    for (int n = 1; n <= 9; n++) begin
      if (w < 5 || w > sz || n == 9) begin e_fault = 2'b01; return; end
      a = ent(ea, b, sz, w);
      want_q.push_back(a);
      d = rd(a);
      if (!d[63]) begin e_fault = 2'b10; return; end
      sz = sz - w;
      if (d[62]) begin
        m = (64'd1 << sz) - 64'd1;
        e_raddr = (d[55:0] & ~m[55:0]) | (ea[55:0] & m[55:0]);
        e_psize = 6'(sz);
        e_leaf  = d;
        e_laddr = a;
        return;
      end
      w = int'(d[4:0]);
      b = {d[55:8], 8'h00};
    end
  endtask

  // Builds a chain of ndir directories then a leaf (or an invalid entry at bad_lvl)
  task automatic mk_chain(input logic [63:0] ea, input logic [55:0] b0, input int w0, input int sz0,
                          input int ndir, input logic [63:0] leafw, input int bad_lvl, input logic [55:0] pool);
    int sz = sz0, w = w0;
    logic [55:0] b = b0, a, nb;
    for (int lv = 0; lv <= ndir; lv++) begin
      if (w < 5 || w > sz) break;
      a = ent(ea, b, sz, w);
      if (lv == bad_lvl) begin mem[a] = 64'd0; break; end
      sz = sz - w;
      if (lv < ndir) begin
        nb = pool + 56'(lv + 1) * 56'h1_0000;
        mem[a] = {2'b10, 6'd0, nb[55:8], 3'd0, 5'(plan[lv])};
        b = nb;
        w = plan[lv];
      end else begin
        mem[a] = leafw;
      end
    end
  endtask

  // Memory responder and per-clock monitor
  always @(negedge clk) begin
    cycles++;
    mem_rvalid_i = 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = rd(pend);
      end
    end
    if (mem_gnt_i) begin
      mem_gnt_i = 1'b0;
    end else if (mem_req_o) begin
      if (!act) chk(1'b0, "R1 request while no walk active", 64'd1, 64'd0);
      if (stall_cnt >= stall_cfg) begin
        mem_gnt_i = 1'b1;
        stall_cnt = 0;
        pend      = mem_addr_o;
        lat_cnt   = lat_cfg;
        if (want_q.size() == 0)
          chk(1'b0, "R2 unexpected entry read", 64'(mem_addr_o), 64'd0);
        else begin
          logic [55:0] w;
          w = want_q.pop_front();
          chk(mem_addr_o == w, "R2 entry address", 64'(mem_addr_o), 64'(w));
        end
      end else begin
        stall_cnt++;
      end
    end
    if (done_o) begin
      if (!act) chk(1'b0, "R9 done without a walk", 64'd1, 64'd0);
      got_done = 1;
      s_fault = fault_o; s_raddr = raddr_o; s_psize = psize_o;
      s_leaf  = leaf_o;  s_laddr = leaf_addr_o;
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_walk(input string tag, input logic [63:0] ea, input logic [55:0] b, input int w,
                          input int sz, input int stall, input int lat, input bit poke);
    int t = 0;
    model_walk(ea, b, w, sz);
    stall_cfg = stall;
    lat_cfg   = lat;
    @(negedge clk);
    ea_i = ea; root_base_i = b; root_isz_i = 5'(w); root_exp_i = 6'(sz);
    got_done = 0;
    act = 1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      @(negedge clk);
      @(negedge clk);
      ea_i = ~ea; root_base_i = b + 56'h800; root_isz_i = 5'd6; root_exp_i = 6'd40;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!got_done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (!got_done) begin
      chk(1'b0, {tag, " walk timed out"}, 64'd0, 64'd1);
      act = 0;
      return;
    end
    chk(s_fault == e_fault, {tag, " fault code"}, 64'(s_fault), 64'(e_fault));
    if (e_fault == 2'b00) begin
      chk(s_raddr == e_raddr, {tag, " real address"}, 64'(s_raddr), 64'(e_raddr));
      chk(s_psize == e_psize, {tag, " page exponent"}, 64'(s_psize), 64'(e_psize));
      chk(s_leaf == e_leaf, {tag, " leaf word"}, s_leaf, e_leaf);
      chk(s_laddr == e_laddr, {tag, " leaf address"}, 64'(s_laddr), 64'(e_laddr));
    end
    chk(want_q.size() == 0, {tag, " R2 all expected reads made"}, 64'(want_q.size()), 64'd0);
    @(negedge clk);
    chk(busy_o == 1'b0, {tag, " R9 idle after done"}, 64'(busy_o), 64'd0);
    act = 0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; ea_i = '0; root_base_i = '0; root_isz_i = '0; root_exp_i = '0;
    mem_gnt_i = 1'b0; mem_rvalid_i = 1'b0; mem_rdata_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy after reset", 64'(busy_o), 64'd0);
    chk(done_o == 1'b0, "R1 done after reset", 64'(done_o), 64'd0);
    chk(mem_req_o == 1'b0, "R1 request after reset", 64'(mem_req_o), 64'd0);
    chk(fault_o == 2'b00, "R1 fault after reset", 64'(fault_o), 64'd0);

    // R3 R4: four levels ending on a 4K leaf
    plan[0] = 9; plan[1] = 9; plan[2] = 9;
    mk_chain(64'h000A_1234_5678_9ABC, 56'h0001_0000, 13, 52, 3, {2'b11, 6'd0, 56'h00_00AB_CDEF_1FFF}, -1, 56'h0100_0000);
    run_walk("R3 R4 4K leaf", 64'h000A_1234_5678_9ABC, 56'h0001_0000, 13, 52, 0, 1, 0);

    // R4: three levels ending on a 2M leaf
    plan[0] = 9; plan[1] = 9;
    mk_chain(64'h0003_3CDE_F012_3456, 56'h0002_0000, 13, 52, 2, {2'b11, 6'd0, 56'h00_0123_4567_89AB}, -1, 56'h0200_0000);
    run_walk("R4 2M leaf", 64'h0003_3CDE_F012_3456, 56'h0002_0000, 13, 52, 0, 1, 0);

    // R8: grant stalls and long read latency
    plan[0] = 9; plan[1] = 9; plan[2] = 9;
    mk_chain(64'h0007_7777_1357_2468, 56'h0003_0000, 13, 52, 3, {2'b11, 6'd0, 56'h00_0FED_CBA9_8000}, -1, 56'h0300_0000);
    run_walk("R8 stalled port", 64'h0007_7777_1357_2468, 56'h0003_0000, 13, 52, 3, 6, 0);

    // R5: invalid entry at the third level
    plan[0] = 9; plan[1] = 9; plan[2] = 9;
    mk_chain(64'h0001_0203_0405_0607, 56'h0004_0000, 13, 52, 3, {2'b11, 6'd0, 56'h0}, 2, 56'h0400_0000);
    run_walk("R5 invalid entry", 64'h0001_0203_0405_0607, 56'h0004_0000, 13, 52, 1, 2, 0);

    // R6: root index width below the minimum, no read at all
    run_walk("R6 root width 4", 64'h0000_1111_2222_3333, 56'h0005_0000, 4, 52, 0, 1, 0);

    // R6: directory supplies width 3
    plan[0] = 3;
    mk_chain(64'h0002_4444_5555_6666, 56'h0006_0000, 13, 52, 1, 64'd0, -1, 56'h0600_0000);
    run_walk("R6 next width 3", 64'h0002_4444_5555_6666, 56'h0006_0000, 13, 52, 0, 1, 0);

    // R6: directory width exceeds the remaining exponent
    plan[0] = 31;
    mk_chain(64'h0005_8888_9999_AAAA, 56'h0007_0000, 25, 52, 1, 64'd0, -1, 56'h0700_0000);
    run_walk("R6 width above exponent", 64'h0005_8888_9999_AAAA, 56'h0007_0000, 25, 52, 0, 1, 0);

    // R7: eight directories in a row
    for (int i = 0; i < 8; i++) plan[i] = 5;
    mk_chain(64'hDEAD_BEEF_CAFE_F00D, 56'h0008_0000, 5, 63, 8, {2'b11, 6'd0, 56'h00_1111_2222_3333}, -1, 56'h0800_0000);
    run_walk("R7 level cap exceeded", 64'hDEAD_BEEF_CAFE_F00D, 56'h0008_0000, 5, 63, 0, 1, 0);

    // R7: exactly eight levels succeed
    for (int i = 0; i < 8; i++) plan[i] = 5;
    mk_chain(64'h1234_5678_9ABC_DEF0, 56'h0009_0000, 5, 63, 7, {2'b11, 6'd0, 56'h00_5555_6666_7777}, -1, 56'h0900_0000);
    run_walk("R7 eight levels", 64'h1234_5678_9ABC_DEF0, 56'h0009_0000, 5, 63, 0, 2, 0);

    // R2: root base with low bits set is treated as aligned
    plan[0] = 9; plan[1] = 9;
    mk_chain(64'h0004_ABCD_0000_1234, 56'h000A_0005, 13, 52, 2, {2'b11, 6'd0, 56'h00_0AAA_BBB0_0000}, -1, 56'h0A00_0000);
    run_walk("R2 unaligned root base", 64'h0004_ABCD_0000_1234, 56'h000A_0005, 13, 52, 0, 1, 0);

    // R9: start pulse during a walk is ignored
    plan[0] = 9; plan[1] = 9; plan[2] = 9;
    mk_chain(64'h0006_0F0F_F0F0_1234, 56'h000B_0000, 13, 52, 3, {2'b11, 6'd0, 56'h00_0C0C_0D0D_E000}, -1, 56'h0B00_0000);
    run_walk("R9 start while busy", 64'h0006_0F0F_F0F0_1234, 56'h000B_0000, 13, 52, 1, 4, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule